// File: doc/BRIEF.md
# Stereo Sample FIFO with Channel Lockstep Guard

This block buffers a stereo audio stream as two sample queues, one for the left channel and one for the right. Each queue has its own storage, its own pointers and its own fill count. The producer writes each channel with its own strobe. The consumer removes the oldest sample of a channel with that channel's read strobe, and the head sample of each queue is always visible on that channel's data output.

A fault can hit only one channel. A write can arrive while one queue is full, or a read can arrive while one queue is empty. When that happens, the two channels would drift apart by one sample. To prevent this, the block uses two small guard state machines, one on the write side and one on the read side. When a fault hits one channel only, the guard swallows the next access to the other channel, exactly once, so that the stream stays paired.

Each guard has three states:
- `GRD_PAIRED`: no access is pending suppression.
- `GRD_SKIP_L`: the next left access will be dropped.
- `GRD_SKIP_R`: the next right access will be dropped.

The guard transitions are:
- **ARM_L** (any state to `GRD_SKIP_L`): a right-only fault.
- **ARM_R** (any state to `GRD_SKIP_R`): a left-only fault.
- **CONSUME** (skip state to `GRD_PAIRED`): the suppressed access has arrived.
- **HOLD**: none of the above.

Four sticky fault bits record the faults. Software-side logic clears them through a write-one-to-clear input.

Top module: `stereo_lockstep_fifo`

## Requirements
- R1: A synchronous reset empties both queues (counts 0, both empty flags high, both full flags low), clears `fault_flags` to 0 and returns both guards to `GRD_PAIRED`.
- R2: A write strobe on a channel that is neither full nor suppressed stores the sample and raises that channel's count by one. The full flag is high exactly when the count equals DEPTH (default 8), and the count never exceeds DEPTH.
- R3: Each channel returns its samples in the order they were written. The read data output shows the oldest sample, and a read strobe on a non-empty, unsuppressed channel removes it and lowers the count by one.
- R4: A write to the right channel while it is full discards that sample and sets `fault_flags[1]`. If the left write in the same cycle is not also a fault, the next left write strobe is dropped.
- R5: A write to the left channel while it is full discards that sample and sets `fault_flags[0]`. If the right write in the same cycle is not also a fault, the next right write strobe is dropped.
- R6: A read of the right channel while it is empty removes nothing and sets `fault_flags[3]`. If the left read in the same cycle is not also a fault, the next left read strobe removes nothing.
- R7: A read of the left channel while it is empty removes nothing and sets `fault_flags[2]`. If the right read in the same cycle is not also a fault, the next right read strobe removes nothing.
- R8: A suppression is one-shot. It drops exactly one access on the partner channel, and the access after that is handled normally.
- R9: `fault_flags` bits stay set until a 1 is written to the same bit of `flag_clr`. If a clear and a new fault on the same bit arrive in the same cycle, the bit stays set.
- R10: When both channels fault in the same cycle on the same side, no suppression is armed.
- R11: A dropped (suppressed) access changes neither count and sets no fault bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_left_en | input | 1 | Left sample write strobe |
| wr_left_data | input | WIDTH | Left sample to store |
| wr_right_en | input | 1 | Right sample write strobe |
| wr_right_data | input | WIDTH | Right sample to store |
| rd_left_en | input | 1 | Left sample read strobe |
| rd_right_en | input | 1 | Right sample read strobe |
| rd_left_data | output | WIDTH | Oldest left sample |
| rd_right_data | output | WIDTH | Oldest right sample |
| left_full | output | 1 | Left queue holds DEPTH samples |
| left_empty | output | 1 | Left queue holds no sample |
| right_full | output | 1 | Right queue holds DEPTH samples |
| right_empty | output | 1 | Right queue holds no sample |
| left_count | output | $clog2(DEPTH+1) | Left fill count |
| right_count | output | $clog2(DEPTH+1) | Right fill count |
| flag_clr | input | 4 | Write-one-to-clear for `fault_flags`, same bit positions |
| fault_flags | output | 4 | Sticky faults: bit 0 left overrun, bit 1 right overrun, bit 2 left underrun, bit 3 right underrun |

## Verification
The assertions take for granted that every strobe and clear input holds a known 0 or 1 at each rising edge once reset has been applied. Two of them take more for granted:
- The check that a rejected write leaves the count unchanged assumes no read of the same channel in that cycle.
- The empty-read check assumes no write of the same channel in that cycle.

The bench changes inputs only on falling edges and holds reset for two edges. Its overrun and underrun scenarios drive the faulting channel without a same-channel access in the opposite direction, so the stimulus stays inside those assumptions.

// File: rtl/stereo_fifo_pkg.sv
package stereo_fifo_pkg;

    typedef enum logic [1:0] {
        GRD_PAIRED = 2'd0,
        GRD_SKIP_L = 2'd1,
        GRD_SKIP_R = 2'd2
    } guard_state_t;

    localparam int NUM_CH = 2;
    localparam int CH_L   = 0;
    localparam int CH_R   = 1;

endpackage

// File: rtl/sf_half.sv
module sf_half #(
    parameter int WIDTH = 20,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic                         pop,
    input  logic [WIDTH-1:0]             din,
    output logic [WIDTH-1:0]             dout,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    fill;

    function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Sample storage, no reset needed
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= advance(wr_ptr);
            if (pop)  rd_ptr <= advance(rd_ptr);
            unique case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_comb begin
        dout  = mem[rd_ptr];
        full  = (fill == CW'(DEPTH));
        empty = (fill == '0);
        count = fill;
    end

endmodule

// File: rtl/sf_guard.sv
module sf_guard
    import stereo_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_l,
    input  logic req_r,
    input  logic blk_l,
    input  logic blk_r,
    output logic go_l,
    output logic go_r,
    output logic fault_l,
    output logic fault_r
);
    guard_state_t state_q;
    guard_state_t state_nxt;
    logic         mask_l;
    logic         mask_r;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= GRD_PAIRED;
        else     state_q <= state_nxt;
    end

    // Outputs: which accesses proceed and which are faults
    always_comb begin
        mask_l = 1'b0;
        mask_r = 1'b0;
        unique case (state_q)
            GRD_PAIRED: ;
            GRD_SKIP_L: mask_l = 1'b1;
            GRD_SKIP_R: mask_r = 1'b1;
            default:    ;
        endcase
        go_l    = req_l & ~mask_l & ~blk_l;
        go_r    = req_r & ~mask_r & ~blk_r;
        fault_l = req_l & ~mask_l &  blk_l;
        fault_r = req_r & ~mask_r &  blk_r;
    end

    // Transitions: CONSUME, then ARM_L / ARM_R override, else HOLD
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            GRD_PAIRED: ;
            GRD_SKIP_L: if (req_l) state_nxt = GRD_PAIRED;
            GRD_SKIP_R: if (req_r) state_nxt = GRD_PAIRED;
            default:    state_nxt = GRD_PAIRED;
        endcase
        if (fault_l && !fault_r) begin
            state_nxt = GRD_SKIP_R;
        end else if (fault_r && !fault_l) begin
            state_nxt = GRD_SKIP_L;
        end
    end

endmodule

// File: rtl/stereo_lockstep_fifo.sv
module stereo_lockstep_fifo
    import stereo_fifo_pkg::*;
#(
    parameter int WIDTH = 20,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_left_en,
    input  logic [WIDTH-1:0]           wr_left_data,
    input  logic                       wr_right_en,
    input  logic [WIDTH-1:0]           wr_right_data,
    input  logic                       rd_left_en,
    input  logic                       rd_right_en,
    output logic [WIDTH-1:0]           rd_left_data,
    output logic [WIDTH-1:0]           rd_right_data,
    output logic                       left_full,
    output logic                       left_empty,
    output logic                       right_full,
    output logic                       right_empty,
    output logic [$clog2(DEPTH+1)-1:0] left_count,
    output logic [$clog2(DEPTH+1)-1:0] right_count,
    input  logic [3:0]                 flag_clr,
    output logic [3:0]                 fault_flags
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [NUM_CH-1:0] wr_req, rd_req, full_v, empty_v;
    logic [NUM_CH-1:0] push_v, pop_v, wfault_v, rfault_v;
    logic [WIDTH-1:0]  din_v  [NUM_CH];
    logic [WIDTH-1:0]  dout_v [NUM_CH];
    logic [CW-1:0]     cnt_v  [NUM_CH];
    logic [3:0]        flags_q;
    logic [3:0]        flags_set;

    always_comb begin
        wr_req        = {wr_right_en, wr_left_en};
        rd_req        = {rd_right_en, rd_left_en};
        din_v[CH_L]   = wr_left_data;
        din_v[CH_R]   = wr_right_data;
    end

    sf_guard u_wr_guard (
        .clk     (clk),
        .rst     (rst),
        .req_l   (wr_req[CH_L]),
        .req_r   (wr_req[CH_R]),
        .blk_l   (full_v[CH_L]),
        .blk_r   (full_v[CH_R]),
        .go_l    (push_v[CH_L]),
        .go_r    (push_v[CH_R]),
        .fault_l (wfault_v[CH_L]),
        .fault_r (wfault_v[CH_R])
    );

    sf_guard u_rd_guard (
        .clk     (clk),
        .rst     (rst),
        .req_l   (rd_req[CH_L]),
        .req_r   (rd_req[CH_R]),
        .blk_l   (empty_v[CH_L]),
        .blk_r   (empty_v[CH_R]),
        .go_l    (pop_v[CH_L]),
        .go_r    (pop_v[CH_R]),
        .fault_l (rfault_v[CH_L]),
        .fault_r (rfault_v[CH_R])
    );

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
            sf_half #(
                .WIDTH (WIDTH),
                .DEPTH (DEPTH)
            ) u_half (
                .clk   (clk),
                .rst   (rst),
                .push  (push_v[ch]),
                .pop   (pop_v[ch]),
                .din   (din_v[ch]),
                .dout  (dout_v[ch]),
                .full  (full_v[ch]),
                .empty (empty_v[ch]),
                .count (cnt_v[ch])
            );
        end
    endgenerate

    // Sticky faults: a new fault wins over a clear of the same bit
    assign flags_set = {rfault_v[CH_R], rfault_v[CH_L], wfault_v[CH_R], wfault_v[CH_L]};

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~flag_clr) | flags_set;
    end

    always_comb begin
        rd_left_data  = dout_v[CH_L];
        rd_right_data = dout_v[CH_R];
        left_full     = full_v[CH_L];
        right_full    = full_v[CH_R];
        left_empty    = empty_v[CH_L];
        right_empty   = empty_v[CH_R];
        left_count    = cnt_v[CH_L];
        right_count   = cnt_v[CH_R];
        fault_flags   = flags_q;
    end

endmodule

// File: rtl/sf_checker.sv
module sf_checker #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_left_en,
    input logic          wr_right_en,
    input logic          rd_left_en,
    input logic          rd_right_en,
    input logic          left_full,
    input logic          right_full,
    input logic          left_empty,
    input logic          right_empty,
    input logic [CW-1:0] left_count,
    input logic [CW-1:0] right_count,
    input logic [3:0]    flag_clr,
    input logic [3:0]    fault_flags
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (left_count == '0 && right_count == '0 && fault_flags == 4'b0000));

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (left_count <= CW'(DEPTH)) && (right_count <= CW'(DEPTH)));

    assert_full_not_empty_R2: assert property (@(posedge clk) disable iff (rst)
        !(left_full && left_empty) && !(right_full && right_empty));

    assert_right_overrun_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_right_en && right_full && !rd_right_en) |=> $stable(right_count));

    assert_left_overrun_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_left_en && left_full && !rd_left_en) |=> $stable(left_count));

    assert_right_underrun_none_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_right_en && right_empty && !wr_right_en) |=> (right_count == '0));

    assert_left_underrun_none_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_left_en && left_empty && !wr_left_en) |=> (left_count == '0));

    assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(fault_flags) & ~$past(flag_clr)) & ~fault_flags) == 4'b0000));

endmodule

bind stereo_lockstep_fifo sf_checker #(
    .DEPTH (DEPTH),
    .CW    ($clog2(DEPTH + 1))
) u_sf_checker (
    .clk         (clk),
    .rst         (rst),
    .wr_left_en  (wr_left_en),
    .wr_right_en (wr_right_en),
    .rd_left_en  (rd_left_en),
    .rd_right_en (rd_right_en),
    .left_full   (left_full),
    .right_full  (right_full),
    .left_empty  (left_empty),
    .right_empty (right_empty),
    .left_count  (left_count),
    .right_count (right_count),
    .flag_clr    (flag_clr),
    .fault_flags (fault_flags)
);

// File: tb/stereo_lockstep_fifo_tb.sv
module stereo_lockstep_fifo_tb;
    localparam int W  = 20;
    localparam int D  = 8;
    localparam int CW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_left_en = 1'b0, wr_right_en = 1'b0;
    logic [W-1:0]  wr_left_data = '0, wr_right_data = '0;
    logic          rd_left_en = 1'b0, rd_right_en = 1'b0;
    logic [W-1:0]  rd_left_data, rd_right_data;
    logic          left_full, left_empty, right_full, right_empty;
    logic [CW-1:0] left_count, right_count;
    logic [3:0]    flag_clr = 4'b0000;
    logic [3:0]    fault_flags;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    stereo_lockstep_fifo #(.WIDTH(W), .DEPTH(D)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .wr_left_en    (wr_left_en),
        .wr_left_data  (wr_left_data),
        .wr_right_en   (wr_right_en),
        .wr_right_data (wr_right_data),
        .rd_left_en    (rd_left_en),
        .rd_right_en   (rd_right_en),
        .rd_left_data  (rd_left_data),
        .rd_right_data (rd_right_data),
        .left_full     (left_full),
        .left_empty    (left_empty),
        .right_full    (right_full),
        .right_empty   (right_empty),
        .left_count    (left_count),
        .right_count   (right_count),
        .flag_clr      (flag_clr),
        .fault_flags   (fault_flags)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what,
                          input longint act, input longint exp);
        chk(act == exp, req, what, act, exp);
    endtask

    // One clock: drive at a falling edge, results settle by the next falling edge
    task automatic cyc(input bit wl, input logic [W-1:0] dl, input bit wr,
                       input logic [W-1:0] dr, input bit rl, input bit rr,
                       input logic [3:0] clr);
        wr_left_en = wl; wr_left_data = dl; wr_right_en = wr; wr_right_data = dr;
        rd_left_en = rl; rd_right_en = rr; flag_clr = clr;
        @(negedge clk);
        wr_left_en = 1'b0; wr_right_en = 1'b0; rd_left_en = 1'b0;
        rd_right_en = 1'b0; flag_clr = 4'b0000;
    endtask

    task automatic do_reset;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        do_reset();
        chk_eq("R1", "left_count", left_count, 0);
        chk_eq("R1", "right_count", right_count, 0);
        chk_eq("R1", "empties", {left_empty, right_empty}, 2'b11);
        chk_eq("R1", "fulls", {left_full, right_full}, 2'b00);
        chk_eq("R1", "fault_flags", fault_flags, 0);
    endtask

    task automatic t_fill_drain;
        do_reset();
        for (int i = 0; i < D; i++) begin
            cyc(1, W'(i * 3), 1, W'(i * 3 + 1), 0, 0, 4'b0);
            chk_eq("R2", "left_count fill", left_count, i + 1);
            chk_eq("R2", "right_count fill", right_count, i + 1);
        end
        chk_eq("R2", "fulls at depth", {left_full, right_full}, 2'b11);
        for (int i = 0; i < D; i++) begin
            chk_eq("R3", "left order", rd_left_data, i * 3);
            chk_eq("R3", "right order", rd_right_data, i * 3 + 1);
            cyc(0, '0, 0, '0, 1, 1, 4'b0);
            chk_eq("R3", "left_count drain", left_count, D - 1 - i);
        end
        chk_eq("R3", "empties after drain", {left_empty, right_empty}, 2'b11);
        chk_eq("R2", "no faults", fault_flags, 0);
    endtask

    task automatic t_right_overrun;
        do_reset();
        for (int i = 0; i < D; i++) cyc(0, '0, 1, W'(100 + i), 0, 0, 4'b0);
        chk_eq("R4", "right full", right_full, 1);
        cyc(1, W'(1), 1, W'(999), 0, 0, 4'b0);
        chk_eq("R4", "left stored", left_count, 1);
        chk_eq("R4", "right dropped", right_count, D);
        chk_eq("R4", "overrun right flag", fault_flags, 4'b0010);
        cyc(0, '0, 0, '0, 0, 1, 4'b0);
        chk_eq("R4", "right head after pop", rd_right_data, 101);
        cyc(1, W'(2), 1, W'(3), 0, 0, 4'b0);
        chk_eq("R4", "next left write swallowed", left_count, 1);
        chk_eq("R11", "swallowed sets no flag", fault_flags, 4'b0010);
        chk_eq("R4", "right stored", right_count, D);
        cyc(1, W'(4), 0, '0, 0, 0, 4'b0);
        chk_eq("R8", "left write after one-shot", left_count, 2);
        chk_eq("R4", "left head", rd_left_data, 1);
    endtask

    task automatic t_left_overrun;
        do_reset();
        for (int i = 0; i < D; i++) cyc(1, W'(200 + i), 0, '0, 0, 0, 4'b0);
        chk_eq("R5", "left full", left_full, 1);
        cyc(1, W'(888), 1, W'(7), 0, 0, 4'b0);
        chk_eq("R5", "right stored", right_count, 1);
        chk_eq("R5", "left dropped", left_count, D);
        chk_eq("R5", "overrun left flag", fault_flags, 4'b0001);
        cyc(0, '0, 0, '0, 1, 0, 4'b0);
        cyc(1, W'(8), 1, W'(9), 0, 0, 4'b0);
        chk_eq("R5", "next right write swallowed", right_count, 1);
        chk_eq("R5", "left stored", left_count, D);
        cyc(0, '0, 1, W'(10), 0, 0, 4'b0);
        chk_eq("R8", "right write after one-shot", right_count, 2);
    endtask

    task automatic t_right_underrun;
        do_reset();
        cyc(1, W'(10), 0, '0, 0, 0, 4'b0);
        cyc(1, W'(11), 0, '0, 0, 0, 4'b0);
        cyc(0, '0, 0, '0, 1, 1, 4'b0);
        chk_eq("R6", "left popped", left_count, 1);
        chk_eq("R6", "left head", rd_left_data, 11);
        chk_eq("R6", "underrun right flag", fault_flags, 4'b1000);
        cyc(0, '0, 0, '0, 1, 0, 4'b0);
        chk_eq("R6", "next left read blocked", left_count, 1);
        chk_eq("R11", "blocked read no flag", fault_flags, 4'b1000);
        cyc(0, '0, 0, '0, 1, 0, 4'b0);
        chk_eq("R8", "left read after one-shot", left_count, 0);
    endtask

    task automatic t_left_underrun;
        do_reset();
        cyc(0, '0, 1, W'(20), 0, 0, 4'b0);
        cyc(0, '0, 1, W'(21), 0, 0, 4'b0);
        cyc(0, '0, 0, '0, 1, 1, 4'b0);
        chk_eq("R7", "right popped", right_count, 1);
        chk_eq("R7", "right head", rd_right_data, 21);
        chk_eq("R7", "underrun left flag", fault_flags, 4'b0100);
        cyc(0, '0, 0, '0, 0, 1, 4'b0);
        chk_eq("R7", "next right read blocked", right_count, 1);
        cyc(0, '0, 0, '0, 0, 1, 4'b0);
        chk_eq("R8", "right read after one-shot", right_count, 0);
    endtask

    task automatic t_both_and_clear;
        do_reset();
        cyc(0, '0, 0, '0, 1, 1, 4'b0);
        chk_eq("R10", "both underrun flags", fault_flags, 4'b1100);
        cyc(1, W'(5), 1, W'(6), 0, 0, 4'b0);
        chk_eq("R10", "pair stored", {left_count, right_count}, {CW'(1), CW'(1)});
        cyc(0, '0, 0, '0, 1, 1, 4'b0);
        chk_eq("R10", "no arm: left popped", left_count, 0);
        chk_eq("R10", "no arm: right popped", right_count, 0);
        cyc(0, '0, 0, '0, 0, 0, 4'b0100);
        chk_eq("R9", "clear bit2 only", fault_flags, 4'b1000);
        cyc(0, '0, 0, '0, 0, 1, 4'b1000);
        chk_eq("R9", "set wins over clear", fault_flags, 4'b1000);
        cyc(0, '0, 0, '0, 0, 0, 4'b1000);
        chk_eq("R9", "clear bit3", fault_flags, 4'b0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_fill_drain();
        t_right_overrun();
        t_left_overrun();
        t_right_underrun();
        t_left_underrun();
        t_both_and_clear();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule